// File: doc/BRIEF.md
# Segmented Pretrigger Event Capture Recorder

This block records three-axis acceleration into a capture memory that is split into equal event segments. It keeps a rolling history of the most recent samples. When a trigger pulse arrives it writes a six-location header into the next free segment and copies out the retained history, oldest sample first. It then stores post-trigger samples until the segment is full, and moves its write base to the following segment. Each stored location keeps the upper byte of every signed 10-bit axis sample.

A host reads the memory through a location pointer that presents two 16-bit words. Every advance strobe, which stands for a read of the second word, moves the pointer on by one, and the host can also load the pointer directly. A 16-bit event counter records every trigger, including those that are not captured, so the host can tell how many events were lost. A full flag tells the host that no room is left for another segment. The sample strobe must have at least one idle cycle between pulses.

Top module: `capt_recorder`

## Requirements
- R1: After reset, `evt_cnt` is 0, `buf_full` is 0 and `rd_ptr` is 0.
- R2: A segment holds NL = 2^max(DEPTH_LOG2-3-len_t, 3) locations. Successive captured events occupy consecutive segments, and the first segment starts at location 0.
- R3: Offsets 0 to 5 of a segment hold the header fields latched at the trigger. Field k is `hdr_fields[16k+15:16k]`, read back as `rd_word1`, and `rd_word2` reads 0 at these offsets.
- R4: Sample 0 is the first sample whose strobe falls at or after the trigger cycle, and it sits at offset S0 = max(6, NL*pre_p/16). The S0-6 samples before it fill offsets 6 to S0-1 in arrival order.
- R5: Post-trigger samples fill offsets S0 to NL-1 in arrival order. After that the segment is complete.
- R6: A stored location reads back as `rd_word1` = {y[9:2], x[9:2]} and `rd_word2` = {8'h00, z[9:2]}.
- R7: `evt_cnt` rises by one for every trigger, whether or not the trigger is captured. It holds otherwise.
- R8: `buf_full` sets when fewer than NL locations remain after a segment completes. While it is set, triggers write nothing to memory.
- R9: A trigger that arrives while an event is still being filled is counted but does not start a capture.
- R10: `ptr_load` loads `ptr_val` into `rd_ptr`, and `rd_adv` adds one, wrapping at the memory depth. When both arrive in the same cycle, the load wins.
- R11: `clr_buf` zeroes `evt_cnt` and `buf_full` and restarts capture at segment 0. A trigger in the same cycle as the clear is neither counted nor captured. `clr_factory` does the same and also zeroes `rd_ptr`.
- R12: When NL*pre_p/16 is below 6, no pretrigger samples are stored and sample 0 sits at offset 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| acc_x | input | 10 | X axis sample, two's complement |
| acc_y | input | 10 | Y axis sample, two's complement |
| acc_z | input | 10 | Z axis sample, two's complement |
| hdr_fields | input | 96 | Six 16-bit header values, field k at bits 16k+15:16k |
| trig | input | 1 | Trigger pulse |
| len_t | input | 3 | Event-length factor |
| pre_p | input | 4 | Pretrigger factor |
| clr_buf | input | 1 | Buffer clear command |
| clr_factory | input | 1 | Full clear command, also zeroes the pointer |
| ptr_load | input | 1 | Load the readback pointer |
| ptr_val | input | DEPTH_LOG2 | Pointer load value |
| rd_adv | input | 1 | Second-word read strobe, advances the pointer |
| rd_word1 | output | 16 | Y byte and X byte at the pointer |
| rd_word2 | output | 16 | Z byte at the pointer |
| rd_ptr | output | DEPTH_LOG2 | Current readback pointer |
| evt_cnt | output | 16 | Trigger counter |
| buf_full | output | 1 | No room for another segment |

## Verification
Two pairs of functions can collide in one cycle. The first is a pointer load with an advance strobe. The second is a clear command with a trigger pulse. The bench drives each pair in the same cycle and then checks the ports: after load plus advance, the pointer must equal the loaded value and not that value plus one. After clear plus trigger, the counter must be zero, the full flag low, and the next capture must land at location 0. A second trigger issued during a segment's header phase checks the same kind of overlap between an event in progress and a new trigger.

// File: rtl/capt_pkg.sv
`timescale 1ns/1ps
package capt_pkg;
    localparam int HDR_WORDS    = 6;
    localparam int FIELD_W      = 16;
    localparam int AXIS_W       = 10;
    localparam int MIN_SEG_LOG2 = 3;

    typedef struct packed {
        logic [7:0] z;
        logic [7:0] y;
        logic [7:0] x;
    } loc_t;

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_COPY} seq_st_e;

    function automatic loc_t pack_sample(input logic [AXIS_W-1:0] x,
                                         input logic [AXIS_W-1:0] y,
                                         input logic [AXIS_W-1:0] z);
        loc_t r;
        r.x = x[AXIS_W-1 -: 8];
        r.y = y[AXIS_W-1 -: 8];
        r.z = z[AXIS_W-1 -: 8];
        return r;
    endfunction

    function automatic int seg_log2(input int depth_log2, input logic [2:0] t);
        int s;
        s = depth_log2 - 3 - int'(t);
        if (s < MIN_SEG_LOG2) s = MIN_SEG_LOG2;
        return s;
    endfunction
endpackage

// File: rtl/capt_history.sv
`timescale 1ns/1ps
module capt_history import capt_pkg::*; #(
    parameter int HIST_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  loc_t                 smp,
    input  logic [HIST_LOG2-1:0] rd_idx,
    output logic [HIST_LOG2-1:0] wr_idx,
    output loc_t                 rd_data
);
    localparam int HIST = 1 << HIST_LOG2;

    loc_t                 ring [HIST];
    logic [HIST_LOG2-1:0] wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= '0;
        else if (smp_vld) wr_q <= wr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (smp_vld) ring[wr_q] <= smp;
    end

    assign wr_idx  = wr_q;
    assign rd_data = ring[rd_idx];

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(wr_q));
endmodule

// File: rtl/capt_sequencer.sv
`timescale 1ns/1ps
module capt_sequencer import capt_pkg::*; #(
    parameter int DEPTH_LOG2 = 11,
    parameter int HIST_LOG2  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         trig,
    input  logic [2:0]                   len_t,
    input  logic [3:0]                   pre_p,
    input  logic [HDR_WORDS*FIELD_W-1:0] hdr_fields,
    input  logic [HIST_LOG2-1:0]         hist_wr_idx,
    input  loc_t                         hist_rd_data,
    output logic [HIST_LOG2-1:0]         hist_rd_idx,
    output logic                         mem_we,
    output logic [DEPTH_LOG2-1:0]        mem_addr,
    output loc_t                         mem_wdata,
    output logic [15:0]                  evt_cnt,
    output logic                         buf_full
);
    localparam int AW = DEPTH_LOG2;
    localparam int CW = AW + 5;
    localparam logic [CW-1:0] DEPTH_C = CW'(1) << AW;

    seq_st_e              st_q;
    logic [CW-1:0]        base_q, nl_q;
    logic [AW-1:0]        ofs_q;
    logic [HIST_LOG2-1:0] rd_q, npre;
    logic [15:0]          evt_q;
    logic                 full_q;
    logic [FIELD_W-1:0]   hdr_q [HDR_WORDS];

    logic [CW-1:0] nl_new, prod, s0_raw, nxt_base;
    logic          fits, have, last_loc, full_next;
    logic [2:0]    hsel;

    assign nl_new    = CW'(1) << seg_log2(DEPTH_LOG2, len_t);
    assign prod      = nl_new * CW'(pre_p);
    assign s0_raw    = prod >> 4;
    assign npre      = (s0_raw > CW'(HDR_WORDS)) ? HIST_LOG2'(s0_raw - CW'(HDR_WORDS)) : '0;
    assign fits      = (base_q + nl_new) <= DEPTH_C;
    assign nxt_base  = base_q + nl_q;
    assign full_next = (DEPTH_C - nxt_base) < nl_q;
    assign have      = (rd_q != hist_wr_idx);
    assign last_loc  = (CW'(ofs_q) == nl_q - 1'b1);
    assign hsel      = ofs_q[2:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            nl_q   <= '0;
            ofs_q  <= '0;
            rd_q   <= '0;
            evt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (trig) evt_q <= evt_q + 1'b1;
            case (st_q)
                ST_IDLE: if (trig && !full_q && fits) begin
                    st_q  <= ST_HDR;
                    ofs_q <= '0;
                    nl_q  <= nl_new;
                    rd_q  <= hist_wr_idx - npre;
                    for (int k = 0; k < HDR_WORDS; k++)
                        hdr_q[k] <= hdr_fields[k*FIELD_W +: FIELD_W];
                end
                ST_HDR: begin
                    ofs_q <= ofs_q + 1'b1;
                    if (ofs_q == AW'(HDR_WORDS - 1)) st_q <= ST_COPY;
                end
                ST_COPY: if (have) begin
                    rd_q  <= rd_q + 1'b1;
                    ofs_q <= ofs_q + 1'b1;
                    if (last_loc) begin
                        st_q   <= ST_IDLE;
                        base_q <= nxt_base;
                        if (full_next) full_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_we      = (st_q == ST_HDR) || ((st_q == ST_COPY) && have);
    assign mem_addr    = AW'(base_q + CW'(ofs_q));
    assign mem_wdata   = (st_q == ST_HDR) ? loc_t'({8'h00, hdr_q[hsel]}) : hist_rd_data;
    assign hist_rd_idx = rd_q;
    assign evt_cnt     = evt_q;
    assign buf_full    = full_q;

    // R2
    ofs_in_seg_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (CW'(ofs_q) < nl_q));
    // R3
    hdr_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && st_q == ST_COPY) |-> (ofs_q >= AW'(HDR_WORDS)));
    // R8
    full_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        full_q |-> !mem_we);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_COPY) |=> (st_q != ST_HDR));
    // R7
    evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && !clr) |=> $stable(evt_q));
endmodule

// File: rtl/capt_store.sv
`timescale 1ns/1ps
module capt_store import capt_pkg::*; #(
    parameter int DEPTH_LOG2 = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [DEPTH_LOG2-1:0] waddr,
    input  loc_t                  wdata,
    input  logic                  ptr_zero,
    input  logic                  ptr_load,
    input  logic [DEPTH_LOG2-1:0] ptr_val,
    input  logic                  rd_adv,
    output logic [DEPTH_LOG2-1:0] ptr,
    output logic [15:0]           word1,
    output logic [15:0]           word2
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    loc_t                  mem [DEPTH];
    logic [DEPTH_LOG2-1:0] ptr_q;
    loc_t                  cur;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || ptr_zero) ptr_q <= '0;
        else if (ptr_load)   ptr_q <= ptr_val;
        else if (rd_adv)     ptr_q <= ptr_q + 1'b1;
    end

    assign cur   = mem[ptr_q];
    assign ptr   = ptr_q;
    assign word1 = {cur.y, cur.x};
    assign word2 = {8'h00, cur.z};

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_adv && !ptr_load && !ptr_zero) |=> $stable(ptr_q));
endmodule

// File: rtl/capt_recorder.sv
`timescale 1ns/1ps
module capt_recorder import capt_pkg::*; #(
    parameter int DEPTH_LOG2 = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         smp_vld,
    input  logic [AXIS_W-1:0]            acc_x,
    input  logic [AXIS_W-1:0]            acc_y,
    input  logic [AXIS_W-1:0]            acc_z,
    input  logic [HDR_WORDS*FIELD_W-1:0] hdr_fields,
    input  logic                         trig,
    input  logic [2:0]                   len_t,
    input  logic [3:0]                   pre_p,
    input  logic                         clr_buf,
    input  logic                         clr_factory,
    input  logic                         ptr_load,
    input  logic [DEPTH_LOG2-1:0]        ptr_val,
    input  logic                         rd_adv,
    output logic [15:0]                  rd_word1,
    output logic [15:0]                  rd_word2,
    output logic [DEPTH_LOG2-1:0]        rd_ptr,
    output logic [15:0]                  evt_cnt,
    output logic                         buf_full
);
    localparam int HIST_LOG2 = DEPTH_LOG2 - 3;

    loc_t                  smp, hist_rd_data, mem_wdata;
    logic [HIST_LOG2-1:0]  hist_wr_idx, hist_rd_idx;
    logic                  mem_we;
    logic [DEPTH_LOG2-1:0] mem_addr;

    assign smp = pack_sample(acc_x, acc_y, acc_z);

    capt_history #(.HIST_LOG2(HIST_LOG2)) u_hist (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
        .rd_idx(hist_rd_idx), .wr_idx(hist_wr_idx), .rd_data(hist_rd_data)
    );

    capt_sequencer #(.DEPTH_LOG2(DEPTH_LOG2), .HIST_LOG2(HIST_LOG2)) u_seq (
        .clk(clk), .rst(rst), .clr(clr_buf || clr_factory), .trig(trig),
        .len_t(len_t), .pre_p(pre_p), .hdr_fields(hdr_fields),
        .hist_wr_idx(hist_wr_idx), .hist_rd_data(hist_rd_data),
        .hist_rd_idx(hist_rd_idx), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .evt_cnt(evt_cnt), .buf_full(buf_full)
    );

    capt_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .ptr_zero(clr_factory), .ptr_load(ptr_load), .ptr_val(ptr_val),
        .rd_adv(rd_adv), .ptr(rd_ptr), .word1(rd_word1), .word2(rd_word2)
    );
endmodule

// File: tb/test_capt_recorder.sv
`timescale 1ns/1ps
module test_capt_recorder;
    localparam int DL    = 8;
    localparam int DEPTH = 1 << DL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_vld = 1'b0;
    logic [9:0]    acc_x = '0, acc_y = '0, acc_z = '0;
    logic [95:0]   hdr_fields = '0;
    logic          trig = 1'b0;
    logic [2:0]    len_t = '0;
    logic [3:0]    pre_p = '0;
    logic          clr_buf = 1'b0, clr_factory = 1'b0;
    logic          ptr_load = 1'b0, rd_adv = 1'b0;
    logic [DL-1:0] ptr_val = '0;
    logic [15:0]   rd_word1, rd_word2, evt_cnt;
    logic [DL-1:0] rd_ptr;
    logic          buf_full;

    int n_chk = 0, n_bad = 0, nsent = 0, exp_evt = 0, base = 0;

    capt_recorder #(.DEPTH_LOG2(DL)) i_capt_recorder (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .acc_x(acc_x), .acc_y(acc_y),
        .acc_z(acc_z), .hdr_fields(hdr_fields), .trig(trig), .len_t(len_t),
        .pre_p(pre_p), .clr_buf(clr_buf), .clr_factory(clr_factory),
        .ptr_load(ptr_load), .ptr_val(ptr_val), .rd_adv(rd_adv),
        .rd_word1(rd_word1), .rd_word2(rd_word2), .rd_ptr(rd_ptr),
        .evt_cnt(evt_cnt), .buf_full(buf_full)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [15:0] hdrw(input int e, input int k);
        return 16'(e * 64 + k * 7 + 5);
    endfunction

    function automatic int seg_len(input int t);
        int s;
        s = DL - 3 - t;
        if (s < 3) s = 3;
        return 1 << s;
    endfunction

    task automatic send_sample();
        logic [7:0] b;
        b = 8'(nsent);
        @(negedge clk);
        smp_vld = 1'b1;
        acc_x = {b, 2'b01};
        acc_y = {~b, 2'b10};
        acc_z = {b ^ 8'h5A, 2'b11};
        @(negedge clk);
        smp_vld = 1'b0;
        nsent++;
    endtask

    task automatic run_event(input int t, input int p, input int e, input bit dbl,
                             output int nl, output int s0, output int n0);
        len_t = 3'(t);
        pre_p = 4'(p);
        for (int k = 0; k < 6; k++) hdr_fields[k*16 +: 16] = hdrw(e, k);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        exp_evt++;
        if (dbl) begin
            // R9: second trigger while the header is being written
            trig = 1'b1;
            @(negedge clk) trig = 1'b0;
            exp_evt++;
        end
        nl = seg_len(t);
        s0 = (nl * p) / 16;
        if (s0 < 6) s0 = 6;
        n0 = nsent;
        repeat (nl - s0) send_sample();
        repeat (40) @(negedge clk);
    endtask

    task automatic verify_seg(input int b, input int nl, input int s0, input int n0,
                              input int e, input string s0tag);
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_val = DL'(b);
        @(negedge clk);
        ptr_load = 1'b0;
        for (int o = 0; o < nl; o++) begin
            logic [31:0] exp;
            string tag;
            int n;
            if (o < 6) begin
                exp = {hdrw(e, o), 16'h0000};
                tag = "R2 R3";
            end else begin
                n = n0 + o - s0;
                exp = {~n[7:0], n[7:0], 8'h00, n[7:0] ^ 8'h5A};
                tag = (o < s0) ? "R4 R6" : ((o == s0) ? s0tag : "R5 R6");
            end
            chk(tag, {rd_word1, rd_word2}, exp);
            rd_adv = 1'b1;
            @(negedge clk);
            rd_adv = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nl, s0, n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 evt", 32'(evt_cnt), 32'd0);
        chk("R1 full", 32'(buf_full), 32'd0);
        chk("R1 ptr", 32'(rd_ptr), 32'd0);

        repeat (40) send_sample();

        // event A: NL=32, P=8 -> sample 0 at offset 16, ten pretrigger samples
        run_event(0, 8, 1, 1'b0, nl, s0, n0);
        verify_seg(base, nl, s0, n0, 1, "R4 R5");
        base += nl;
        chk("R7 evt", 32'(evt_cnt), 32'(exp_evt));

        // event B: NL=16, P=0 -> no pretrigger (R12)
        run_event(1, 0, 2, 1'b0, nl, s0, n0);
        verify_seg(base, nl, s0, n0, 2, "R12");
        base += nl;

        // event C: NL=8, P=15 -> one pretrigger sample, extra trigger while busy
        run_event(2, 15, 3, 1'b1, nl, s0, n0);
        verify_seg(base, nl, s0, n0, 3, "R4 R5");
        base += nl;
        chk("R9 R7 evt", 32'(evt_cnt), 32'(exp_evt));

        // fill the remaining segments
        for (int e = 4; base < DEPTH; e++) begin
            if (base + 8 == DEPTH) chk("R8 not full yet", 32'(buf_full), 32'd0);
            run_event(2, 15, e, 1'b0, nl, s0, n0);
            verify_seg(base, nl, s0, n0, e, "R2 R5");
            base += nl;
        end
        chk("R8 full", 32'(buf_full), 32'd1);

        // trigger while full: counted, segment 0 untouched
        run_event(2, 15, 200, 1'b0, nl, s0, n0);
        chk("R8 R7 evt", 32'(evt_cnt), 32'(exp_evt));
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_val = '0;
        @(negedge clk);
        ptr_load = 1'b0;
        chk("R8 seg0 hdr", {16'h0000, rd_word1}, {16'h0000, hdrw(1, 0)});

        // R10: load and advance in the same cycle, then wrap
        ptr_load = 1'b1;
        rd_adv = 1'b1;
        ptr_val = DL'(77);
        @(negedge clk);
        ptr_load = 1'b0;
        rd_adv = 1'b0;
        chk("R10 load wins", 32'(rd_ptr), 32'd77);
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        chk("R10 advance", 32'(rd_ptr), 32'd78);
        ptr_load = 1'b1;
        ptr_val = DL'(DEPTH - 1);
        @(negedge clk);
        ptr_load = 1'b0;
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        chk("R10 wrap", 32'(rd_ptr), 32'd0);

        // R11: clear and trigger in the same cycle
        clr_buf = 1'b1;
        trig = 1'b1;
        @(negedge clk);
        clr_buf = 1'b0;
        trig = 1'b0;
        chk("R11 evt", 32'(evt_cnt), 32'd0);
        chk("R11 full", 32'(buf_full), 32'd0);
        exp_evt = 0;
        base = 0;
        run_event(2, 15, 99, 1'b0, nl, s0, n0);
        verify_seg(base, nl, s0, n0, 99, "R11");
        chk("R11 evt after", 32'(evt_cnt), 32'(exp_evt));

        ptr_load = 1'b1;
        ptr_val = DL'(5);
        @(negedge clk);
        ptr_load = 1'b0;
        clr_factory = 1'b1;
        @(negedge clk);
        clr_factory = 1'b0;
        chk("R11 factory ptr", 32'(rd_ptr), 32'd0);
        chk("R11 factory evt", 32'(evt_cnt), 32'd0);

        finish_run();
    end
endmodule